// File: doc/BRIEF.md
# Gated card clock divider

This block derives the card clock for an SD/MMC host from the function clock. The ratio comes from an 8-bit rate value N and a quarter-rate option. With the option off, the clock is high for N+1 function-clock cycles and low for N+1. With it on, each half lasts 2·(N+1) cycles. A new N or option setting is taken only at a period boundary, so each period is built from one setting.

The card clock stops at a low level in three cases: software clears the enable, the receive shift path reports full, or the transmit shift path reports empty. A stop request never shortens a phase. A high phase in progress runs to its end, and the low phase that follows also runs to its end, before the clock is held. A status output reports when the clock is being held. Two single-cycle ticks mark the first function-clock cycle of each high phase and of each low phase, so the shift engines can act on card clock edges without sampling the clock itself.

Top module: `sdclk_gen`

## Requirements
- R1: While reset is asserted and after it is released, card_clk_o, rise_tick_o and fall_tick_o are 0. With clk_en_i at 0, stopped_o is 1 from the first cycle after reset.
- R2: With quarter_i at 0 and a steady rate N, each high phase and each low phase lasts N+1 function-clock cycles, so the period is 2·(N+1).
- R3: With quarter_i at 1 and a steady rate N, each high phase and each low phase lasts 2·(N+1) function-clock cycles, so the period is 4·(N+1).
- R4: Reset loads an applied rate of 255 with quarter mode off. The first high phase after reset therefore lasts 256 cycles whatever rate_i is. rate_i takes effect from the first falling edge on.
- R5: When clk_en_i drops to 0, the high phase in progress completes at full length and the following low phase also completes. The clock then stays low. stopped_o is 0 during the ordinary low phase and becomes 1 in its last cycle. It stays 1 while the clock is held.
- R6: rx_full_i at 1 stops the clock in exactly the way R5 describes.
- R7: tx_empty_i at 1 stops the clock in exactly the way R5 describes.
- R8: rate_i and quarter_i are sampled in the cycle the clock falls and in every cycle while the clock is held. A change made during a high phase leaves that phase's length unchanged and applies from the next low phase on.
- R9: rise_tick_o is 1 exactly in the first function-clock cycle of each high phase. fall_tick_o is 1 exactly in the first cycle of each low phase. Both are 0 in every other cycle.
- R10: While the clock is held, releasing every stop condition (clk_en_i 1, rx_full_i 0, tx_empty_i 0) drives the clock high at the next function-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Software enable for the card clock |
| rate_i | input | 8 | Rate value N |
| quarter_i | input | 1 | Selects the 4·(N+1) ratio |
| rx_full_i | input | 1 | Receive shift path full, stall request |
| tx_empty_i | input | 1 | Transmit shift path empty, stall request |
| card_clk_o | output | 1 | Card clock, registered |
| rise_tick_o | output | 1 | First cycle of each high phase |
| fall_tick_o | output | 1 | First cycle of each low phase |
| stopped_o | output | 1 | Clock is being held low |

## Verification
A wrong phase counter shows at the ports as a high or low run of the wrong length. The error is visible within one half-period, so the bench measures every run in function-clock cycles over a sweep of rate values and both ratio modes. A wrong applied-rate register shows up at the first falling edge after a change, or in the first high phase after reset. A gating fault appears as a clock edge while a stop condition is present, or as a missing edge in the cycle after release. A tick that drifts from the clock level is caught in the cycle it happens, because every sample compares the ticks against the clock level of the previous cycle.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } card_lvl_e;

   // The card clock may start a new high phase only when no stop condition holds.
   function automatic logic may_run(input logic en, input logic rx_full, input logic tx_empty);
      return en & ~rx_full & ~tx_empty;
   endfunction

endpackage

// File: rtl/sdclk_rate_shadow.sv
module sdclk_rate_shadow #(
   parameter int              RATE_W     = 8,
   parameter bit              QUARTER_EN = 1'b1,
   parameter logic [RATE_W-1:0] RESET_RATE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              quarter_i,
   output logic [RATE_W-1:0] rate_o,
   output logic              quarter_o
);

   logic [RATE_W-1:0] rate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rate_q <= RESET_RATE;
      else if (load_i) rate_q <= rate_i;
   end
   assign rate_o = rate_q;

   generate
      if (QUARTER_EN) begin : g_quarter
         logic quarter_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      quarter_q <= 1'b0;
            else if (load_i) quarter_q <= quarter_i;
         end
         assign quarter_o = quarter_q;
      end else begin : g_half_only
         logic unused_quarter;
         assign unused_quarter = quarter_i;
         assign quarter_o      = 1'b0;
      end
   endgenerate

   // Applied rate changes only at a load point (R8)
   assert_rate_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(rate_q));

endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] reload_cur_i,
   input  logic [CNT_W-1:0] reload_new_i,
   output logic             clk_o,
   output logic             rise_o,
   output logic             fall_o,
   output logic             at_end_o,
   output logic             load_o
);
   import sdclk_pkg::*;

   card_lvl_e        lvl_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rise_q;
   logic             fall_q;
   logic             end_w;

   assign end_w = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= LVL_LOW;
         cnt_q  <= '0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         if (end_w) begin
            if (lvl_q == LVL_HIGH) begin
               lvl_q  <= LVL_LOW;
               cnt_q  <= reload_new_i;
               fall_q <= 1'b1;
            end else if (run_i) begin
               lvl_q  <= LVL_HIGH;
               cnt_q  <= reload_cur_i;
               rise_q <= 1'b1;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign clk_o    = (lvl_q == LVL_HIGH);
   assign rise_o   = rise_q;
   assign fall_o   = fall_q;
   assign at_end_o = end_w & (lvl_q == LVL_LOW);
   assign load_o   = end_w & ((lvl_q == LVL_HIGH) | ~run_i);

   // A rising edge is only started when no stop condition was present (R5, R6, R7)
   assert_rise_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_o) |-> $past(run_i));

   // A high phase with count left is never cut short (R5)
   assert_no_runt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_o && !end_w) |=> clk_o);

   // At most one edge tick per cycle (R9)
   assert_tick_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise_q, fall_q}));

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
   parameter int RATE_W     = 8,
   parameter bit QUARTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              quarter_i,
   input  logic              rx_full_i,
   input  logic              tx_empty_i,
   output logic              card_clk_o,
   output logic              rise_tick_o,
   output logic              fall_tick_o,
   output logic              stopped_o
);
   import sdclk_pkg::*;

   localparam int CNT_W = RATE_W + (QUARTER_EN ? 1 : 0);

   generate
      if (RATE_W < 1 || RATE_W > 16) begin : g_bad_width
         $error("sdclk_gen: RATE_W must lie in 1..16");
      end
   endgenerate

   logic              run_w;
   logic              load_w;
   logic              at_end_w;
   logic [RATE_W-1:0] rate_cur_w;
   logic              quarter_cur_w;
   logic [CNT_W-1:0]  reload_cur_w;
   logic [CNT_W-1:0]  reload_new_w;

   assign run_w = may_run(clk_en_i, rx_full_i, tx_empty_i);

   sdclk_rate_shadow #(
      .RATE_W    (RATE_W),
      .QUARTER_EN(QUARTER_EN),
      .RESET_RATE({RATE_W{1'b1}})
   ) i_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_w),
      .rate_i   (rate_i),
      .quarter_i(quarter_i),
      .rate_o   (rate_cur_w),
      .quarter_o(quarter_cur_w)
   );

   // Half-period minus one: N for the 2(N+1) ratio, 2N+1 for the 4(N+1) ratio
   generate
      if (QUARTER_EN) begin : g_reload_quarter
         assign reload_cur_w = quarter_cur_w ? {rate_cur_w, 1'b1} : {1'b0, rate_cur_w};
         assign reload_new_w = quarter_i     ? {rate_i, 1'b1}     : {1'b0, rate_i};
      end else begin : g_reload_half
         logic unused_cur_quarter;
         assign unused_cur_quarter = quarter_cur_w;
         assign reload_cur_w = rate_cur_w;
         assign reload_new_w = rate_i;
      end
   endgenerate

   sdclk_phase #(
      .CNT_W(CNT_W)
   ) i_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (run_w),
      .reload_cur_i(reload_cur_w),
      .reload_new_i(reload_new_w),
      .clk_o       (card_clk_o),
      .rise_o      (rise_tick_o),
      .fall_o      (fall_tick_o),
      .at_end_o    (at_end_w),
      .load_o      (load_w)
   );

   assign stopped_o = at_end_w & ~run_w;

   // Held status never coincides with a high clock (R5)
   assert_stopped_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stopped_o |-> !card_clk_o);

   // A held clock stays low into the next cycle (R6, R7)
   assert_hold_keeps_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stopped_o |=> !card_clk_o);

   // Release from a held state raises the clock at the next edge (R10)
   assert_release_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end_w && run_w) |=> card_clk_o);

endmodule

// File: tb/test_sdclk_gen.sv
`timescale 1ns/1ps
module test_sdclk_gen;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       clk_en;
   logic [7:0] rate;
   logic       quarter;
   logic       rx_full;
   logic       tx_empty;
   logic       card_clk;
   logic       rise_tick;
   logic       fall_tick;
   logic       stopped;

   int n_chk = 0;
   int n_bad = 0;
   int tick_err = 0;
   int n_rise = 0;
   logic prev_ck = 1'b0;

   always #2 clk = ~clk;

   sdclk_gen i_sdclk_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en_i   (clk_en),
      .rate_i     (rate),
      .quarter_i  (quarter),
      .rx_full_i  (rx_full),
      .tx_empty_i (tx_empty),
      .card_clk_o (card_clk),
      .rise_tick_o(rise_tick),
      .fall_tick_o(fall_tick),
      .stopped_o  (stopped)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // Tick monitor: ticks must follow the clock level of the previous sample (R9)
   always @(negedge clk) begin
      if (rst_n) begin
         if (rise_tick !== (card_clk & ~prev_ck)) tick_err++;
         if (fall_tick !== (~card_clk & prev_ck)) tick_err++;
         if (rise_tick === 1'b1) n_rise++;
         prev_ck = card_clk;
      end else begin
         prev_ck = 1'b0;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   // Counts consecutive samples at level lvl, starting from the current one.
   task automatic count_level(input logic lvl, output int n);
      n = 0;
      while (card_clk === lvl) begin
         n++;
         @(negedge clk);
      end
   endtask

   // Stops the clock, applies a configuration, restarts; returns at the first high sample.
   task automatic configure(input int n_rate, input bit q);
      @(negedge clk);
      clk_en = 1'b0;
      while (stopped !== 1'b1) @(negedge clk);
      rate    = 8'(n_rate);
      quarter = q;
      repeat (2) @(negedge clk);
      clk_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic stall_test(input int which, input string tag);
      int h;
      int highs;
      configure(3, 1'b0);
      case (which)
         0:       clk_en   = 1'b0;
         1:       rx_full  = 1'b1;
         default: tx_empty = 1'b1;
      endcase
      count_level(1'b1, h);
      check(h == 4, tag, h, 4);
      check(stopped == 1'b0, tag, stopped, 0);
      highs = 0;
      for (int i = 0; i < 40; i++) begin
         if (card_clk !== 1'b0) highs++;
         @(negedge clk);
      end
      check(highs == 0, tag, highs, 0);
      check(stopped == 1'b1, tag, stopped, 1);
      clk_en   = 1'b1;
      rx_full  = 1'b0;
      tx_empty = 1'b0;
      @(negedge clk);
      check(card_clk == 1'b1, "R10", card_clk, 1);
      check(rise_tick == 1'b1, "R10", rise_tick, 1);
   endtask

   initial begin
      int h;
      int l;
      int h2;
      int exp_h;
      rst_n    = 1'b0;
      clk_en   = 1'b0;
      rate     = 8'd0;
      quarter  = 1'b0;
      rx_full  = 1'b0;
      tx_empty = 1'b0;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(card_clk == 1'b0, "R1", card_clk, 0);
      check({rise_tick, fall_tick} == 2'b00, "R1", {rise_tick, fall_tick}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(stopped == 1'b1, "R1", stopped, 1);
      h = 0;
      for (int i = 0; i < 8; i++) begin
         if (card_clk !== 1'b0) h++;
         @(negedge clk);
      end
      check(h == 0, "R5", h, 0);

      // R4: reset rate applies to the first high phase
      rst_n  = 1'b0;
      clk_en = 1'b1;
      rate   = 8'd0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(card_clk == 1'b1, "R4", card_clk, 1);
      count_level(1'b1, h);
      count_level(1'b0, l);
      count_level(1'b1, h2);
      check(h == 256, "R4", h, 256);
      check(l == 1, "R4", l, 1);
      check(h2 == 1, "R4", h2, 1);

      // R2 / R3: sweep of rate values in both ratio modes
      for (int qi = 0; qi < 2; qi++) begin
         for (int ni = 0; ni < 10; ni++) begin
            int nv;
            nv = (ni < 8) ? ni : ((ni == 8) ? 100 : 255);
            exp_h = (qi == 1) ? 2 * (nv + 1) : (nv + 1);
            configure(nv, qi[0]);
            count_level(1'b1, h);
            count_level(1'b0, l);
            count_level(1'b1, h2);
            if (qi == 1) begin
               check(h == exp_h, "R3", h, exp_h);
               check(l == exp_h, "R3", l, exp_h);
               check(h2 == exp_h, "R3", h2, exp_h);
            end else begin
               check(h == exp_h, "R2", h, exp_h);
               check(l == exp_h, "R2", l, exp_h);
               check(h2 == exp_h, "R2", h2, exp_h);
            end
         end
      end

      // R8: rate change during a high phase applies from the next low phase
      configure(1, 1'b0);
      check(rise_tick == 1'b1, "R9", rise_tick, 1);
      rate = 8'd4;
      count_level(1'b1, h);
      check(fall_tick == 1'b1, "R9", fall_tick, 1);
      count_level(1'b0, l);
      count_level(1'b1, h2);
      check(h == 2, "R8", h, 2);
      check(l == 5, "R8", l, 5);
      check(h2 == 5, "R8", h2, 5);

      // R8: quarter switch during a high phase
      configure(2, 1'b0);
      quarter = 1'b1;
      count_level(1'b1, h);
      count_level(1'b0, l);
      check(h == 3, "R8", h, 3);
      check(l == 6, "R8", l, 6);

      // R5, R6, R7: each stop condition, then R10 release
      stall_test(0, "R5");
      stall_test(1, "R6");
      stall_test(2, "R7");

      repeat (4) @(negedge clk);
      check(tick_err == 0, "R9", tick_err, 0);
      check(n_rise > 20, "R9", n_rise, 21);
      finish_run();
   end

endmodule